// File: doc/BRIEF.md
# Memory-Mapped Device Router with UART Queue Ports

This block sits between the load/store port of a 32-bit CPU and the memory-mapped devices beside system RAM. It decodes each bus address and separates the low RAM range from a small window of device registers at a fixed high base. Its first client is a UART, reached through a transmit queue and a receive queue that live outside the block.

A store to the transmit data register takes one byte out of the 32-bit store word, using the byte-lane write mask. In the same cycle it raises a one-cycle push strobe into the transmit queue. A read from the receive data register returns the byte at the head of the receive queue and pulses a pop strobe. A read from the receive count register returns how many bytes are waiting. The block drives one busy line, formed as the OR of per-device busy terms, so the CPU holds its request while a queue cannot take or supply a byte. Nothing is dropped. All decode and steering is combinational, so an accepted access completes in the cycle it is presented.

Top module: `mmio_router`

## Requirements
- R1: Addresses below 0x00040000 (system RAM) are not claimed: `dev_sel`, `tx_push`, `rx_pop` and `cpu_busy` stay 0 and `cpu_rdata` is 0.
- R2: A store (`cpu_we`=1) to 0x8000000C while `tx_full`=0 raises `tx_push` in that same cycle, and `cpu_busy` stays 0.
- R3: The pushed byte comes from the lowest set bit of `cpu_wmask`, with bit k selecting `cpu_wdata[8k+7:8k]`. A store whose mask is 0 pushes nothing.
- R4: A store to the transmit register while `tx_full`=1 holds `cpu_busy`=1 and `tx_push`=0. Once `tx_full` falls with the store still presented, the byte is pushed.
- R5: A read (`cpu_re`=1) from 0x80000008 while `rx_empty`=0 returns {24'b0, `rx_byte`}, pulses `rx_pop` in that cycle and leaves `cpu_busy` at 0.
- R6: A read from 0x80000008 while `rx_empty`=1 holds `cpu_busy`=1 and `rx_pop`=0.
- R7: A read from 0x80000004 returns `rx_count` zero-extended to 32 bits, without `rx_pop` and without busy.
- R8: The reserved words 0x80000000 and 0x80000010–0x8000001C, and reads of the transmit register, return 0 with no busy, no push and no pop. Stores to reserved words push nothing.
- R9: Only address bits [31:2] are decoded. For example, a store to 0x8000000F acts exactly like one to 0x8000000C.
- R10: `cpu_busy` is the OR of the transmit and receive busy terms, and it is never 1 without `cpu_we` or `cpu_re`.
- R11: `dev_sel` is 1 only for addresses from 0x80000000 to 0x8000001F. An address just past that range, such as 0x80000020, is unclaimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock (times the checks) |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store word |
| cpu_wmask | input | 4 | Byte-lane write mask, bit k = byte k |
| cpu_we | input | 1 | Store request |
| cpu_re | input | 1 | Load request |
| cpu_rdata | output | 32 | Load result |
| cpu_busy | output | 1 | Stall: request cannot complete this cycle |
| dev_sel | output | 1 | Address falls in the device window |
| tx_full | input | 1 | Transmit queue cannot accept a byte |
| tx_push | output | 1 | Transmit queue write strobe |
| tx_byte | output | 8 | Byte written into the transmit queue |
| rx_empty | input | 1 | Receive queue holds no byte |
| rx_byte | input | 8 | Head byte of the receive queue |
| rx_count | input | 10 | Bytes waiting in the receive queue |
| rx_pop | output | 1 | Receive queue read strobe |

## Verification
The bench drives a full transmit queue under a held store, then releases it. A design that drops or duplicates the byte would show a push while busy, or no push after space returns. It walks every single-bit write mask and several multi-bit masks, where a wrong lane picker would push the wrong byte. It also reads the empty receive port, where a faulty design would pop garbage instead of stalling. The window edges 0x8000001C and 0x80000020, the RAM top, and an unaligned alias of the transmit register are each probed. These catch decoders that use the low address bits or compare the range off by one.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_RAM,
    TGT_RX_CNT,
    TGT_RX_DATA,
    TGT_TX_DATA,
    TGT_RSVD
  } tgt_e;

  // lowest enabled byte lane of a store word
  function automatic logic [7:0] pick_lane(input logic [31:0] word,
                                           input logic [3:0]  mask);
    logic [7:0] b;
    b = 8'h00;
    for (int k = 3; k >= 0; k--) begin
      if (mask[k]) b = word[8*k +: 8];
    end
    return b;
  endfunction

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter logic [31:0] DEV_BASE  = 32'h8000_0000,
  parameter logic [31:0] RAM_TOP   = 32'h0004_0000,
  parameter int          NUM_SLOTS = 8,
  parameter int          SLOT_RXC  = 1,
  parameter int          SLOT_RXD  = 2,
  parameter int          SLOT_TX   = 3
) (
  input  logic [31:0] addr,
  output tgt_e        tgt,
  output logic        in_win
);
  localparam int          SLOT_W    = $clog2(NUM_SLOTS);
  localparam logic [29:0] BASE_WORD = DEV_BASE[31:2];
  localparam logic [29:0] SLOT_LIM  = 30'(NUM_SLOTS);

  logic [29:0]       word;
  logic [29:0]       offset;
  logic [SLOT_W-1:0] slot;

  assign word   = addr[31:2];
  assign offset = word - BASE_WORD;
  assign slot   = offset[SLOT_W-1:0];
  assign in_win = (word >= BASE_WORD) && (offset < SLOT_LIM);

  always_comb begin
    if (addr < RAM_TOP)       tgt = TGT_RAM;
    else if (!in_win)         tgt = TGT_NONE;
    else if (32'(slot) == SLOT_RXC) tgt = TGT_RX_CNT;
    else if (32'(slot) == SLOT_RXD) tgt = TGT_RX_DATA;
    else if (32'(slot) == SLOT_TX)  tgt = TGT_TX_DATA;
    else                      tgt = TGT_RSVD;
  end
endmodule

// File: rtl/mmio_tx_port.sv
module mmio_tx_port
  import mmio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic [3:0]  wmask,
  input  logic        tx_full,
  output logic        tx_push,
  output logic [7:0]  tx_byte,
  output logic        tx_busy
);
  logic store_req;

  assign store_req = sel && we && (|wmask);
  assign tx_busy   = store_req && tx_full;
  assign tx_push   = store_req && !tx_full;
  assign tx_byte   = pick_lane(wdata, wmask);

  assert_push_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> !tx_full);
  assert_push_or_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_push && tx_busy));
  assert_empty_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wmask == 4'b0000) |-> !tx_push);
endmodule

// File: rtl/mmio_rx_port.sv
module mmio_rx_port #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_data,
  input  logic             sel_cnt,
  input  logic             re,
  input  logic             rx_empty,
  input  logic [7:0]       rx_byte,
  input  logic [CNT_W-1:0] rx_count,
  output logic             rx_pop,
  output logic             rx_busy,
  output logic [31:0]      rd_word
);
  logic data_req;

  assign data_req = sel_data && re;
  assign rx_busy  = data_req && rx_empty;
  assign rx_pop   = data_req && !rx_empty;

  always_comb begin
    rd_word = 32'h0;
    if (rx_pop)            rd_word = {24'h0, rx_byte};
    else if (sel_cnt && re) rd_word = 32'(rx_count);
  end

  assert_pop_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> !rx_empty);
  assert_empty_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_req && rx_empty) |-> (rx_busy && !rx_pop));
  assert_count_no_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cnt |-> !rx_pop);
endmodule

// File: rtl/mmio_router.sv
module mmio_router
  import mmio_pkg::*;
#(
  parameter logic [31:0] DEV_BASE  = 32'h8000_0000,
  parameter logic [31:0] RAM_TOP   = 32'h0004_0000,
  parameter int          NUM_SLOTS = 8,
  parameter int          CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cpu_addr,
  input  logic [31:0]      cpu_wdata,
  input  logic [3:0]       cpu_wmask,
  input  logic             cpu_we,
  input  logic             cpu_re,
  output logic [31:0]      cpu_rdata,
  output logic             cpu_busy,
  output logic             dev_sel,
  input  logic             tx_full,
  output logic             tx_push,
  output logic [7:0]       tx_byte,
  input  logic             rx_empty,
  input  logic [7:0]       rx_byte,
  input  logic [CNT_W-1:0] rx_count,
  output logic             rx_pop
);
  tgt_e        tgt;
  logic        in_win;
  logic        tx_busy;
  logic        rx_busy;
  logic [31:0] rx_word;

  mmio_decode #(
    .DEV_BASE (DEV_BASE),
    .RAM_TOP  (RAM_TOP),
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_RXC (1),
    .SLOT_RXD (2),
    .SLOT_TX  (3)
  ) u_decode (
    .addr  (cpu_addr),
    .tgt   (tgt),
    .in_win(in_win)
  );

  mmio_tx_port u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (tgt == TGT_TX_DATA),
    .we     (cpu_we),
    .wdata  (cpu_wdata),
    .wmask  (cpu_wmask),
    .tx_full(tx_full),
    .tx_push(tx_push),
    .tx_byte(tx_byte),
    .tx_busy(tx_busy)
  );

  mmio_rx_port #(.CNT_W(CNT_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_data(tgt == TGT_RX_DATA),
    .sel_cnt (tgt == TGT_RX_CNT),
    .re      (cpu_re),
    .rx_empty(rx_empty),
    .rx_byte (rx_byte),
    .rx_count(rx_count),
    .rx_pop  (rx_pop),
    .rx_busy (rx_busy),
    .rd_word (rx_word)
  );

  assign dev_sel   = in_win;
  assign cpu_busy  = tx_busy | rx_busy;
  assign cpu_rdata = cpu_re ? rx_word : 32'h0;

  assert_busy_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_busy |-> (cpu_we || cpu_re));
  assert_ram_unclaimed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < RAM_TOP) |-> (!dev_sel && !tx_push && !rx_pop && !cpu_busy));
  assert_strobe_in_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push || rx_pop) |-> dev_sel);
endmodule

// File: tb/mmio_router_tb.sv
module mmio_router_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_wmask = '0;
  logic        cpu_we = 1'b0, cpu_re = 1'b0;
  logic [31:0] cpu_rdata;
  logic        cpu_busy, dev_sel;
  logic        tx_full = 1'b0, tx_push;
  logic [7:0]  tx_byte;
  logic        rx_empty = 1'b1;
  logic [7:0]  rx_byte = '0;
  logic [9:0]  rx_count = '0;
  logic        rx_pop;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmio_router u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wmask(cpu_wmask), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy), .dev_sel(dev_sel),
    .tx_full(tx_full), .tx_push(tx_push), .tx_byte(tx_byte),
    .rx_empty(rx_empty), .rx_byte(rx_byte), .rx_count(rx_count),
    .rx_pop(rx_pop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // present inputs after a falling edge, settle, compare before next rise
  task automatic idle();
    @(negedge clk);
    cpu_we = 0; cpu_re = 0; cpu_wmask = 0;
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wmask = m; cpu_we = 1; cpu_re = 0;
    #1;
  endtask

  task automatic load(input logic [31:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_we = 0; cpu_re = 1; cpu_wmask = 0;
    #1;
  endtask

  function automatic logic [7:0] ref_lane(input logic [31:0] w, input logic [3:0] m);
    if (m[0]) return w[7:0];
    if (m[1]) return w[15:8];
    if (m[2]) return w[23:16];
    return w[31:24];
  endfunction

  task automatic t_reset();
    #1;
    chk("reset R10 busy", {31'b0, cpu_busy}, 0);
    chk("reset R2 push", {31'b0, tx_push}, 0);
    chk("reset R5 pop", {31'b0, rx_pop}, 0);
  endtask

  task automatic t_ram();
    store(32'h0000_100C, 32'hAABBCCDD, 4'hF);
    chk("R1 sel", {31'b0, dev_sel}, 0);
    chk("R1 push", {31'b0, tx_push}, 0);
    store(32'h0003_FFFC, 32'h11223344, 4'h1);
    chk("R1 top push", {31'b0, tx_push}, 0);
    chk("R1 top busy", {31'b0, cpu_busy}, 0);
    rx_empty = 0;
    load(32'h0000_0008);
    chk("R1 pop", {31'b0, rx_pop}, 0);
    chk("R1 rdata", cpu_rdata, 0);
    rx_empty = 1;
    idle();
  endtask

  task automatic t_tx_lanes();
    logic [3:0] masks [6] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'hC, 4'h6};
    foreach (masks[i]) begin
      store(32'h8000_000C, 32'hA1B2C3D4 ^ (i << 8), masks[i]);
      chk("R2 push", {31'b0, tx_push}, 1);
      chk("R2 busy", {31'b0, cpu_busy}, 0);
      chk("R3 lane", {24'b0, tx_byte}, {24'b0, ref_lane(32'hA1B2C3D4 ^ (i << 8), masks[i])});
    end
    store(32'h8000_000C, 32'h12345678, 4'h0);
    chk("R3 zero mask", {31'b0, tx_push}, 0);
    idle();
  endtask

  task automatic t_tx_full();
    tx_full = 1;
    store(32'h8000_000C, 32'h0000_005A, 4'h1);
    for (int c = 0; c < 3; c++) begin
      chk("R4 stall busy", {31'b0, cpu_busy}, 1);
      chk("R4 stall push", {31'b0, tx_push}, 0);
      @(negedge clk); #1;
    end
    tx_full = 0; #1;
    chk("R4 release push", {31'b0, tx_push}, 1);
    chk("R4 release byte", {24'b0, tx_byte}, 32'h5A);
    chk("R10 release busy", {31'b0, cpu_busy}, 0);
    idle();
  endtask

  task automatic t_rx();
    rx_empty = 0; rx_byte = 8'hC7;
    load(32'h8000_0008);
    chk("R5 data", cpu_rdata, 32'h0000_00C7);
    chk("R5 pop", {31'b0, rx_pop}, 1);
    chk("R5 busy", {31'b0, cpu_busy}, 0);
    rx_empty = 1; #1;
    chk("R6 busy", {31'b0, cpu_busy}, 1);
    chk("R6 pop", {31'b0, rx_pop}, 0);
    rx_count = 10'h3FF;
    load(32'h8000_0004);
    chk("R7 count", cpu_rdata, 32'h0000_03FF);
    chk("R7 pop", {31'b0, rx_pop}, 0);
    chk("R7 busy", {31'b0, cpu_busy}, 0);
    idle();
  endtask

  task automatic t_reserved();
    logic [31:0] rs [5] = '{32'h8000_0000, 32'h8000_0010, 32'h8000_0014,
                            32'h8000_0018, 32'h8000_001C};
    rx_empty = 0; rx_count = 10'd7;
    foreach (rs[i]) begin
      load(rs[i]);
      chk("R8 rdata", cpu_rdata, 0);
      chk("R8 busy", {31'b0, cpu_busy}, 0);
      chk("R8 pop", {31'b0, rx_pop}, 0);
      chk("R11 sel", {31'b0, dev_sel}, 1);
      store(rs[i], 32'hFFFF_FFFF, 4'hF);
      chk("R8 push", {31'b0, tx_push}, 0);
    end
    load(32'h8000_000C);
    chk("R8 tx read", cpu_rdata, 0);
    chk("R8 tx read pop", {31'b0, rx_pop}, 0);
    rx_empty = 1;
    idle();
  endtask

  task automatic t_alias_edges();
    store(32'h8000_000F, 32'h0000_9900, 4'h2);
    chk("R9 alias push", {31'b0, tx_push}, 1);
    chk("R9 alias byte", {24'b0, tx_byte}, 32'h99);
    store(32'h8000_0020, 32'h0000_0011, 4'h1);
    chk("R11 past sel", {31'b0, dev_sel}, 0);
    chk("R11 past push", {31'b0, tx_push}, 0);
    store(32'h7FFF_FFFC, 32'h0000_0011, 4'h1);
    chk("R11 below sel", {31'b0, dev_sel}, 0);
    store(32'h9000_000C, 32'h0000_0011, 4'h1);
    chk("R11 high push", {31'b0, tx_push}, 0);
    idle();
  endtask

  initial begin
    fork
      begin
        t_reset();
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_ram();
        t_tx_lanes();
        t_tx_full();
        t_rx();
        t_reserved();
        t_alias_edges();
        repeat (2) @(posedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule